// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block is the combinational selection logic that decides, for every operand consumer in a five-stage integer pipeline, whether the value read earlier from the register file is still current or whether a newer result further down the pipe must be taken instead. It looks at the instruction class and register fields held in the three pipeline registers that follow decode. These are named here after the stage pair they sit between: ID/EX, EX/MEM and MEM/WB. For each consumer it drives a mux select.

Three results can be bypassed:
- the ALU result held in EX/MEM;
- the ALU result held in MEM/WB;
- the loaded memory word held in MEM/WB.

Four consumers are served:
- the two ALU inputs of the instruction in execute;
- the store data of a store in execute;
- the zero-test input of a branch in execute;
- the write-data port of the data memory for a store in the memory stage whose data comes from the load just ahead of it.

Load-use stalls are decided elsewhere. This block only routes values that already exist.

Top module: `operand_bypass_select`

## Requirements
- R1: The 2-bit selects `alu_a_sel`, `alu_b_sel`, `st_data_sel` and `zero_sel` are encoded as follows: 0 = value from the register file, 1 = EX/MEM ALU result, 2 = MEM/WB ALU result, 3 = MEM/WB loaded word. A select is 0 whenever no applicable bypass matches.
- R2: Instruction class codes are 0 idle, 1 register-register, 2 register-immediate, 3 load, 4 store, 5 branch. A producer writes its `rd` field if it is class 1, and its `rt` field if it is class 2 or 3. Stores, branches and idle slots produce nothing.
- R3: When the EX/MEM producer and the MEM/WB producer both write the register a consumer reads, the EX/MEM result is chosen (select 1).
- R4: A consumer that reads register 0 always gets select 0, and `mem_wdata_sel` stays 0 for register 0.
- R5: A load in EX/MEM is never a bypass source, because its ALU result is an address. A consumer that matches it falls through to the MEM/WB check.
- R6: A matching MEM/WB producer gives select 3 if it is a load and select 2 if it is class 1 or 2.
- R7: `alu_a_sel` follows `idex_rs` for classes 1 to 4 in ID/EX, and is 0 for any other class.
- R8: `alu_b_sel` follows `idex_rt` only for class 1 in ID/EX, and is 0 for every other class.
- R9: `st_data_sel` follows `idex_rt` only for a store in ID/EX.
- R10: `zero_sel` follows `idex_rs` only for a branch in ID/EX.
- R11: `mem_wdata_sel` is 1 exactly when EX/MEM holds a store, MEM/WB holds a load, and the load's `rt` is non-zero and equal to the store's `rt`.
- R12: Class codes 6 and 7 act as idle, both as producers and as consumers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_kind | input | 3 | Class of the instruction in execute |
| idex_rs | input | REG_BITS | First source register in execute |
| idex_rt | input | REG_BITS | Second source register in execute |
| exmem_kind | input | 3 | Class of the instruction in the memory stage |
| exmem_rt | input | REG_BITS | rt field in the memory stage |
| exmem_rd | input | REG_BITS | rd field in the memory stage |
| memwb_kind | input | 3 | Class of the instruction in write-back |
| memwb_rt | input | REG_BITS | rt field in write-back |
| memwb_rd | input | REG_BITS | rd field in write-back |
| alu_a_sel | output | 2 | Source select for ALU input A |
| alu_b_sel | output | 2 | Source select for ALU input B |
| st_data_sel | output | 2 | Source select for store data in execute |
| zero_sel | output | 2 | Source select for the branch zero test |
| mem_wdata_sel | output | 1 | 1 selects the MEM/WB loaded word as data-memory write data |

## Verification
The embedded assertions guard these invariants on every evaluation:
- register 0 is never bypassed;
- the loaded-word code only appears behind a load in write-back;
- the EX/MEM code only appears behind a register-register or register-immediate producer;
- each consumer select stays 0 unless the execute-stage class uses that consumer.

Only the bench scenarios show that the chosen source is the right one. That covers the priority when both stages match, the fall-through past a load in EX/MEM, and the choice of rd versus rt as destination. For these the bench sweeps every class combination against a small register set and compares with an arithmetic model.

// File: rtl/operand_bypass_select.sv
module operand_bypass_select #(
  parameter int REG_BITS = 5
) (
  input  logic [2:0]          idex_kind,
  input  logic [REG_BITS-1:0] idex_rs,
  input  logic [REG_BITS-1:0] idex_rt,
  input  logic [2:0]          exmem_kind,
  input  logic [REG_BITS-1:0] exmem_rt,
  input  logic [REG_BITS-1:0] exmem_rd,
  input  logic [2:0]          memwb_kind,
  input  logic [REG_BITS-1:0] memwb_rt,
  input  logic [REG_BITS-1:0] memwb_rd,
  output logic [1:0]          alu_a_sel,
  output logic [1:0]          alu_b_sel,
  output logic [1:0]          st_data_sel,
  output logic [1:0]          zero_sel,
  output logic                mem_wdata_sel
);

  localparam logic [2:0] K_RR = 3'd1;
  localparam logic [2:0] K_RI = 3'd2;
  localparam logic [2:0] K_LD = 3'd3;
  localparam logic [2:0] K_ST = 3'd4;
  localparam logic [2:0] K_BR = 3'd5;

  localparam logic [1:0] S_REG = 2'd0;
  localparam logic [1:0] S_EXM = 2'd1;
  localparam logic [1:0] S_WBA = 2'd2;
  localparam logic [1:0] S_WBL = 2'd3;

  logic                ex_wr, wb_wr, wb_ld;
  logic [REG_BITS-1:0] ex_dst, wb_dst;
  logic                use_a, use_b, use_st, use_z;

  // EX/MEM loads carry an address, not data, so they are not producers here
  assign ex_wr  = (exmem_kind == K_RR) || (exmem_kind == K_RI);
  assign ex_dst = (exmem_kind == K_RR) ? exmem_rd : exmem_rt;

  assign wb_ld  = (memwb_kind == K_LD);
  assign wb_wr  = (memwb_kind == K_RR) || (memwb_kind == K_RI) || wb_ld;
  assign wb_dst = (memwb_kind == K_RR) ? memwb_rd : memwb_rt;

  assign use_a  = (idex_kind == K_RR) || (idex_kind == K_RI) ||
                  (idex_kind == K_LD) || (idex_kind == K_ST);
  assign use_b  = (idex_kind == K_RR);
  assign use_st = (idex_kind == K_ST);
  assign use_z  = (idex_kind == K_BR);

  function automatic logic [1:0] route(
    input logic                en,
    input logic [REG_BITS-1:0] r,
    input logic                exw,
    input logic [REG_BITS-1:0] exd,
    input logic                wbw,
    input logic [REG_BITS-1:0] wbd,
    input logic                wbl
  );
    if (!en || r == '0)           return S_REG;
    if (exw && exd == r)          return S_EXM;
    if (wbw && wbd == r)          return wbl ? S_WBL : S_WBA;
    return S_REG;
  endfunction

  assign alu_a_sel   = route(use_a,  idex_rs, ex_wr, ex_dst, wb_wr, wb_dst, wb_ld);
  assign alu_b_sel   = route(use_b,  idex_rt, ex_wr, ex_dst, wb_wr, wb_dst, wb_ld);
  assign st_data_sel = route(use_st, idex_rt, ex_wr, ex_dst, wb_wr, wb_dst, wb_ld);
  assign zero_sel    = route(use_z,  idex_rs, ex_wr, ex_dst, wb_wr, wb_dst, wb_ld);

  assign mem_wdata_sel = (exmem_kind == K_ST) && wb_ld &&
                         (memwb_rt != '0) && (memwb_rt == exmem_rt);

  always_comb begin
    a_r4_rs_zero: assert (idex_rs != '0 || (alu_a_sel == S_REG && zero_sel == S_REG))
      else $error("register 0 bypassed on rs");
    a_r4_rt_zero: assert (idex_rt != '0 || (alu_b_sel == S_REG && st_data_sel == S_REG))
      else $error("register 0 bypassed on rt");
    a_r6_lmd_from_load: assert (!(alu_a_sel == S_WBL || alu_b_sel == S_WBL ||
                                  st_data_sel == S_WBL || zero_sel == S_WBL) ||
                                memwb_kind == K_LD)
      else $error("loaded-word select without a load in write-back");
    a_r5_exmem_alu_only: assert (!(alu_a_sel == S_EXM || alu_b_sel == S_EXM ||
                                   st_data_sel == S_EXM || zero_sel == S_EXM) ||
                                 exmem_kind == K_RR || exmem_kind == K_RI)
      else $error("EX/MEM select without an ALU producer");
    a_r8_b_rr_only: assert (alu_b_sel == S_REG || idex_kind == K_RR)
      else $error("ALU B bypass outside register-register");
    a_r10_zero_branch_only: assert (zero_sel == S_REG || idex_kind == K_BR)
      else $error("zero-test bypass outside branch");
    a_r11_wdata_pair: assert (!mem_wdata_sel ||
                              (exmem_kind == K_ST && memwb_kind == K_LD && exmem_rt != '0))
      else $error("write-data bypass without store behind load");
  end

endmodule

// File: tb/operand_bypass_select_test.sv
module operand_bypass_select_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] ik, ek, wk;
  logic [1:0] irs, irt, ert, erd, wrt, wrd;
  logic [1:0] a_sel, b_sel, s_sel, z_sel;
  logic       m_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  operand_bypass_select #(.REG_BITS(2)) uut (
    .idex_kind(ik), .idex_rs(irs), .idex_rt(irt),
    .exmem_kind(ek), .exmem_rt(ert), .exmem_rd(erd),
    .memwb_kind(wk), .memwb_rt(wrt), .memwb_rd(wrd),
    .alu_a_sel(a_sel), .alu_b_sel(b_sel), .st_data_sel(s_sel),
    .zero_sel(z_sel), .mem_wdata_sel(m_sel)
  );

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ik=%0d ek=%0d wk=%0d rs=%0d rt=%0d ert=%0d erd=%0d wrt=%0d wrd=%0d got %0d expected %0d",
               tag, ik, ek, wk, irs, irt, ert, erd, wrt, wrd, got, exp);
    end
  endtask

  // model: MEM/WB first, EX/MEM overrides (R3); EX/MEM load skipped (R5); reg 0 never (R4)
  function automatic logic [1:0] want(input logic [1:0] r);
    logic [1:0] s = 2'd0;
    if (r != 2'd0) begin
      case (wk)
        3'd1: if (wrd == r) s = 2'd2;
        3'd2: if (wrt == r) s = 2'd2;
        3'd3: if (wrt == r) s = 2'd3;
        default: ;
      endcase
      case (ek)
        3'd1: if (erd == r) s = 2'd1;
        3'd2: if (ert == r) s = 2'd1;
        default: ;
      endcase
    end
    return s;
  endfunction

  task automatic set(input logic [2:0] a, input logic [1:0] b, input logic [1:0] c,
                     input logic [2:0] d, input logic [1:0] e, input logic [1:0] f,
                     input logic [2:0] g, input logic [1:0] h, input logic [1:0] i);
    ik = a; irs = b; irt = c; ek = d; ert = e; erd = f; wk = g; wrt = h; wrd = i;
    #1;
  endtask

  task automatic full_check();
    logic [1:0] ea, eb, es, ez;
    logic em;
    ea = (ik >= 3'd1 && ik <= 3'd4) ? want(irs) : 2'd0;
    eb = (ik == 3'd1) ? want(irt) : 2'd0;
    es = (ik == 3'd4) ? want(irt) : 2'd0;
    ez = (ik == 3'd5) ? want(irs) : 2'd0;
    em = (ek == 3'd4 && wk == 3'd3 && wrt != 2'd0 && wrt == ert);
    chk("R7 alu_a", a_sel, ea);
    chk("R8 alu_b", b_sel, eb);
    chk("R9 st_data", s_sel, es);
    chk("R10 zero", z_sel, ez);
    chk("R11 mem_wdata", {1'b0, m_sel}, {1'b0, em});
  endtask

  initial begin
    set(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle pipe, everything from the register file
    set(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 idle a", a_sel, 0); chk("R1 idle b", b_sel, 0);
    chk("R1 idle z", z_sel, 0); chk("R1 idle m", {1'b0, m_sel}, 0);
    // R2: register-register producer writes rd, not rt
    set(1, 2, 1, 1, 2, 1, 0, 0, 0);
    chk("R2 rd dest a", a_sel, 0); chk("R2 rd dest b", b_sel, 1);
    // R2: store produces nothing
    set(1, 1, 0, 4, 1, 1, 0, 0, 0);
    chk("R2 store no dest", a_sel, 0);
    // R3: both stages match, EX/MEM wins
    set(2, 1, 0, 2, 1, 0, 1, 0, 1);
    chk("R3 priority", a_sel, 1);
    // R4: register 0 never bypassed
    set(1, 0, 0, 1, 0, 0, 3, 0, 0);
    chk("R4 zero a", a_sel, 0); chk("R4 zero b", b_sel, 0);
    // R5: EX/MEM load skipped, MEM/WB used
    set(1, 1, 0, 3, 1, 0, 2, 1, 0);
    chk("R5 load skip", a_sel, 2);
    // R6: MEM/WB load gives loaded word to base and store data
    set(4, 3, 3, 0, 0, 0, 3, 3, 0);
    chk("R6 lmd a", a_sel, 3); chk("R6 lmd st", s_sel, 3);
    // R10: branch zero test bypassed, ALU A not
    set(5, 1, 0, 1, 0, 1, 0, 0, 0);
    chk("R10 branch z", z_sel, 1); chk("R10 branch a", a_sel, 0);
    // R11: store behind load
    set(0, 0, 0, 4, 3, 0, 3, 3, 0);
    chk("R11 ld-st", {1'b0, m_sel}, 1);
    set(0, 0, 0, 4, 0, 0, 3, 0, 0);
    chk("R11 reg0", {1'b0, m_sel}, 0);
    // R12: codes 6 and 7 idle
    set(7, 1, 1, 1, 1, 1, 0, 0, 0);
    chk("R12 consumer7 a", a_sel, 0); chk("R12 consumer7 b", b_sel, 0);
    set(1, 1, 1, 6, 1, 1, 7, 1, 1);
    chk("R12 producer a", a_sel, 0);

    // sweep: all class codes, register values {0,1,3}
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 8; d++)
        for (int g = 0; g < 8; g++)
          for (int v = 0; v < 729; v++) begin
            logic [1:0] rv [6];
            int t;
            t = v;
            for (int k = 0; k < 6; k++) begin
              rv[k] = (t % 3 == 2) ? 2'd3 : 2'(t % 3);
              t = t / 3;
            end
            set(3'(a), rv[0], rv[1], 3'(d), rv[2], rv[3], 3'(g), rv[4], rv[5]);
            full_check();
          end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule